// File: doc/BRIEF.md
# Gigabit Media-Independent Transmit Framer

This block turns a payload supplied one byte per cycle by an upper layer into a complete Ethernet frame on an 8-bit GMII transmit port running at 125 MHz (1000 Mb/s). The upper layer raises a start request. The block then sends a preamble and start delimiter, followed by the configured destination and source station addresses and the length/type field. After that it pulls the payload bytes, adds zero padding when the payload is short, and closes the frame with a CRC-32 frame check sequence.

A sequencer counts bytes inside each phase (idle, gap, preamble, delimiter, destination, source, type, data, pad, check sequence) and moves to the next phase when the count is reached. After every frame it enforces a minimum idle gap before a new request is accepted. Payload bytes are pulled, not pushed. While `pl_take` is high, the byte on `pl_data` is consumed at the next clock edge. The source must keep a valid byte on `pl_data` throughout that window and flag the final byte with `pl_last`.

Top module: `gmii_frame_tx`

## Requirements
- R1: While `rst` is high and after its release without a request, `gmii_tx_en`, `gmii_tx_er`, `gmii_txd` and `pl_take` are all 0.
- R2: Each frame opens with PRE_LEN (7) bytes of 0x55 followed by one byte 0xD5. These are the first enabled bytes of the frame.
- R3: After the delimiter come six destination bytes and then six source bytes, each address sent from bits 47:40 down to bits 7:0.
- R4: Two type bytes follow, bits 15:8 first then bits 7:0. The bench configures 0x0800 (IP payload).
- R5: While `pl_take` is high, one payload byte is consumed per clock and sent unchanged and in order. The byte presented with `pl_last` is the last payload byte.
- R6: A payload shorter than MIN_PAYLOAD (46) bytes is followed by 0x00 bytes until exactly 46 data bytes have been sent. A payload of 46 bytes or more gets no padding.
- R7: The frame ends with four check bytes. They are the complement of a reflected CRC-32 (polynomial 0xEDB88320, start value 0xFFFFFFFF) over every byte from the first destination byte through the last data or pad byte, and are sent bits 7:0 first.
- R8: `gmii_tx_en` stays high without a break from the first preamble byte through the last check byte, and `gmii_tx_er` is always 0.
- R9: Between the last check byte of one frame and the first preamble byte of the next, `gmii_tx_en` is low for at least IFG_BYTES (12) cycles. With a request held continuously, the gap is exactly 12.
- R10: `tx_req` is sampled only when the block is idle. A request raised and dropped while a frame is in progress starts no frame.
- R11: The CRC register is reloaded before every frame, so back-to-back frames with the same content carry the same check bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dst | input | 48 | Destination station address |
| cfg_src | input | 48 | Source station address |
| cfg_type | input | 16 | Length/type field value |
| tx_req | input | 1 | Start a frame when idle |
| pl_data | input | 8 | Current payload byte |
| pl_last | input | 1 | Marks `pl_data` as the final payload byte |
| pl_take | output | 1 | Payload byte is consumed at this clock edge |
| gmii_txd | output | 8 | GMII transmit data |
| gmii_tx_en | output | 1 | GMII transmit enable |
| gmii_tx_er | output | 1 | GMII transmit error, held low |

## Verification
The bench builds the block with its defaults: a 7-byte preamble, a 46-byte minimum payload and a 12-byte gap. Payload lengths of 1, 10, 45, 46, 47 and 100 bytes land on both sides of the padding boundary and exercise the saturating data counter beyond it. A request held across two frames measures the gap at exactly its minimum and shows the CRC is reloaded. A short request pulse in the middle of a frame shows that requests outside the idle state are ignored.

// File: rtl/gmii_tx_pkg.sv
package gmii_tx_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_SFD,
        S_DST,
        S_SRC,
        S_TYPE,
        S_DATA,
        S_PAD,
        S_FCS,
        S_GAP
    } tx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       en;
    } gmii_beat_t;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [31:0] CRC_POLY_REF  = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT      = 32'hFFFFFFFF;

    // One byte of the reflected CRC-32, data bit 0 first.
    function automatic logic [31:0] crc32_byte(input logic [31:0] crc_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        c = crc_in ^ {24'd0, d};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ({1'b0, c[31:1]} ^ CRC_POLY_REF) : {1'b0, c[31:1]};
        end
        return c;
    endfunction

    // Byte idx of a 48-bit address, idx 0 being bits 47:40.
    function automatic logic [7:0] addr_byte(input logic [47:0] a,
                                             input logic [2:0]  idx);
        logic [7:0] r;
        r = 8'd0;
        for (int k = 0; k < 6; k++) begin
            if (idx == 3'(k)) r = a[8*(5-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/gmii_tx_crc.sv
module gmii_tx_crc
    import gmii_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc_q <= CRC_INIT;
        end else if (en) begin
            crc_q <= crc32_byte(crc_q, data);
        end
    end

    // The register only moves on a reload or a covered byte.
    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(init) && !$past(en)) |-> $stable(crc_q));

    // A reload leaves the start value in place before the next frame.
    assert_crc_reload_R11: assert property (@(posedge clk) disable iff (rst)
        $past(init) |-> (crc_q == CRC_INIT));

endmodule

// File: rtl/gmii_tx_seq.sv
module gmii_tx_seq
    import gmii_tx_pkg::*;
#(
    parameter int PRE_LEN     = 7,
    parameter int MIN_PAYLOAD = 46,
    parameter int IFG_BYTES   = 12,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_req,
    input  logic             pl_last,
    output tx_state_e        st,
    output logic [CNT_W-1:0] cnt
);

    localparam int GAP_CYC = IFG_BYTES - 1;
    localparam int PW      = $clog2(MIN_PAYLOAD + 1);

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    cnt <= '0;
                    if (tx_req) st <= S_PRE;
                end
                S_PRE: begin
                    if (cnt == CNT_W'(PRE_LEN - 1)) begin
                        st  <= S_SFD;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_SFD: begin
                    st   <= S_DST;
                    cnt  <= '0;
                    pcnt <= '0;
                end
                S_DST, S_SRC: begin
                    if (cnt == CNT_W'(5)) begin
                        st  <= (st == S_DST) ? S_SRC : S_TYPE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TYPE: begin
                    if (cnt == CNT_W'(1)) begin
                        st  <= S_DATA;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (pcnt != PW'(MIN_PAYLOAD)) pcnt <= pcnt + 1'b1;
                    if (pl_last) begin
                        st  <= (pcnt >= PW'(MIN_PAYLOAD - 1)) ? S_FCS : S_PAD;
                        cnt <= '0;
                    end
                end
                S_PAD: begin
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == PW'(MIN_PAYLOAD - 1)) begin
                        st  <= S_FCS;
                        cnt <= '0;
                    end
                end
                S_FCS: begin
                    if (cnt == CNT_W'(3)) begin
                        st  <= S_GAP;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_GAP: begin
                    if (cnt == CNT_W'(GAP_CYC - 1)) begin
                        st  <= S_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    st  <= S_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

    // The gap can only run out into idle, never straight into a new frame.
    assert_gap_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (st == S_GAP) |=> (st == S_GAP || st == S_IDLE));

    // The check sequence is never reached before the minimum payload is covered.
    assert_pad_done_R6: assert property (@(posedge clk) disable iff (rst)
        (st == S_FCS && $past(st) != S_FCS) |-> ($past(pcnt) >= PW'(MIN_PAYLOAD - 1)));

endmodule

// File: rtl/gmii_frame_tx.sv
module gmii_frame_tx
    import gmii_tx_pkg::*;
#(
    parameter int PRE_LEN     = 7,
    parameter int MIN_PAYLOAD = 46,
    parameter int IFG_BYTES   = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [47:0] cfg_dst,
    input  logic [47:0] cfg_src,
    input  logic [15:0] cfg_type,
    input  logic        tx_req,
    input  logic [7:0]  pl_data,
    input  logic        pl_last,
    output logic        pl_take,
    output logic [7:0]  gmii_txd,
    output logic        gmii_tx_en,
    output logic        gmii_tx_er
);

    localparam int CNT_MAX   = (PRE_LEN > IFG_BYTES) ? PRE_LEN : IFG_BYTES;
    localparam int CNT_W     = $clog2(CNT_MAX + 7);
    localparam int MIN_ON    = PRE_LEN + 1 + 6 + 6 + 2 + MIN_PAYLOAD + 4;
    localparam int IW        = $clog2(IFG_BYTES + 1);

    tx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      crc_q;
    gmii_beat_t       beat_d, beat_q;
    logic             crc_init, crc_en;

    gmii_tx_seq #(
        .PRE_LEN     (PRE_LEN),
        .MIN_PAYLOAD (MIN_PAYLOAD),
        .IFG_BYTES   (IFG_BYTES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tx_req  (tx_req),
        .pl_last (pl_last),
        .st      (st),
        .cnt     (cnt)
    );

    assign crc_init = (st == S_IDLE) || (st == S_SFD);
    assign crc_en   = (st == S_DST) || (st == S_SRC) || (st == S_TYPE) ||
                      (st == S_DATA) || (st == S_PAD);

    gmii_tx_crc u_crc (
        .clk   (clk),
        .rst   (rst),
        .init  (crc_init),
        .en    (crc_en),
        .data  (beat_d.data),
        .crc_q (crc_q)
    );

    assign pl_take = (st == S_DATA);

    always_comb begin
        beat_d = '0;
        case (st)
            S_PRE:  beat_d = '{data: PREAMBLE_BYTE, en: 1'b1};
            S_SFD:  beat_d = '{data: SFD_BYTE, en: 1'b1};
            S_DST:  beat_d = '{data: addr_byte(cfg_dst, cnt[2:0]), en: 1'b1};
            S_SRC:  beat_d = '{data: addr_byte(cfg_src, cnt[2:0]), en: 1'b1};
            S_TYPE: beat_d = '{data: cnt[0] ? cfg_type[7:0] : cfg_type[15:8], en: 1'b1};
            S_DATA: beat_d = '{data: pl_data, en: 1'b1};
            S_PAD:  beat_d = '{data: 8'h00, en: 1'b1};
            S_FCS:  beat_d = '{data: ~crc_q[8*cnt[1:0] +: 8], en: 1'b1};
            default: beat_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= beat_d;
    end

    assign gmii_txd   = beat_q.data;
    assign gmii_tx_en = beat_q.en;
    assign gmii_tx_er = 1'b0;

    // Run-length counters on the transmit enable, used only by the properties.
    logic [IW-1:0] idle_run;
    logic [15:0]   on_run;
    logic          seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run   <= '0;
            on_run     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (gmii_tx_en) begin
                idle_run   <= '0;
                seen_frame <= 1'b1;
                if (on_run != 16'hFFFF) on_run <= on_run + 1'b1;
            end else begin
                on_run <= '0;
                if (idle_run != IW'(IFG_BYTES)) idle_run <= idle_run + 1'b1;
            end
        end
    end

    assert_first_byte_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(gmii_tx_en) |-> (gmii_txd == PREAMBLE_BYTE));

    assert_min_gap_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(gmii_tx_en) && seen_frame) |-> (idle_run == IW'(IFG_BYTES)));

    assert_min_frame_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(gmii_tx_en) |-> (on_run >= 16'(MIN_ON)));

    assert_take_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        pl_take |-> gmii_tx_en);

endmodule

// File: tb/sim_gmii_frame_tx.sv
module sim_gmii_frame_tx;

    localparam int CLK_PERIOD = 8;
    localparam logic [47:0] DST = 48'h0A1B2C3D4E5F;
    localparam logic [47:0] SRC = 48'h021122334455;
    localparam logic [15:0] TYP = 16'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_req = 1'b0;
    logic [7:0]  pl_data;
    logic        pl_last;
    logic        pl_take;
    logic [7:0]  gmii_txd;
    logic        gmii_tx_en;
    logic        gmii_tx_er;

    int total = 0;
    int bad = 0;

    logic [7:0] pay [0:127];
    int plen = 1;
    int idx = 0;

    logic [7:0] cap [0:255];
    int cap_len = 0;
    int frames_done = 0;
    int low_run = 1000;
    int last_gap = 0;
    logic prev_en = 1'b0;
    logic er_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gmii_frame_tx u0 (
        .clk        (clk),
        .rst        (rst),
        .cfg_dst    (DST),
        .cfg_src    (SRC),
        .cfg_type   (TYP),
        .tx_req     (tx_req),
        .pl_data    (pl_data),
        .pl_last    (pl_last),
        .pl_take    (pl_take),
        .gmii_txd   (gmii_txd),
        .gmii_tx_en (gmii_tx_en),
        .gmii_tx_er (gmii_tx_er)
    );

    assign pl_data = pay[idx[6:0]];
    assign pl_last = (idx == plen - 1);

    always @(posedge clk) begin
        if (pl_take) idx <= pl_last ? 0 : idx + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (gmii_tx_er) er_seen = 1'b1;
            if (gmii_tx_en) begin
                if (!prev_en) begin
                    cap_len  = 0;
                    last_gap = low_run;
                    low_run  = 0;
                end
                cap[cap_len[7:0]] = gmii_txd;
                cap_len++;
            end else begin
                if (prev_en) frames_done++;
                low_run++;
            end
            prev_en = gmii_tx_en;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = r[0] ^ d[i];
            r = r >> 1;
            if (fb) r = r ^ 32'hEDB88320;
        end
        return r;
    endfunction

    task automatic fill(input int n, input int seed);
        plen = n;
        for (int i = 0; i < 128; i++) pay[i] = 8'(seed + i * 7 + 1);
    endtask

    task automatic check_frame(input int n, input string tag);
        int dlen, exp_len, pos, first_bad;
        logic [31:0] c;
        logic [31:0] fcs;
        logic ok;
        dlen = (n < 46) ? 46 : n;
        exp_len = 8 + 14 + dlen + 4;
        check(cap_len == exp_len, {"R8 length ", tag}, cap_len, exp_len);
        ok = 1'b1;
        for (int i = 0; i < 7; i++) if (cap[i] != 8'h55) ok = 1'b0;
        check(ok && cap[7] == 8'hD5, {"R2 preamble ", tag}, cap[7], 8'hD5);
        ok = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (cap[8 + i] != DST[8*(5-i) +: 8]) ok = 1'b0;
            if (cap[14 + i] != SRC[8*(5-i) +: 8]) ok = 1'b0;
        end
        check(ok, {"R3 addresses ", tag}, {cap[8], cap[14]}, {DST[47:40], SRC[47:40]});
        check(cap[20] == TYP[15:8] && cap[21] == TYP[7:0], {"R4 type ", tag},
              {cap[20], cap[21]}, TYP);
        first_bad = -1;
        for (int i = 0; i < n; i++) if (first_bad < 0 && cap[22 + i] != pay[i]) first_bad = i;
        check(first_bad < 0, {"R5 payload ", tag},
              (first_bad < 0) ? 0 : cap[22 + first_bad], (first_bad < 0) ? 0 : pay[first_bad]);
        first_bad = -1;
        for (int i = n; i < dlen; i++) if (first_bad < 0 && cap[22 + i] != 8'h00) first_bad = i;
        check(first_bad < 0, {"R6 padding ", tag},
              (first_bad < 0) ? 0 : cap[22 + first_bad], 0);
        c = 32'hFFFFFFFF;
        for (int i = 8; i < 22 + dlen; i++) c = ref_crc(c, cap[i]);
        fcs = ~c;
        pos = 22 + dlen;
        check({cap[pos+3], cap[pos+2], cap[pos+1], cap[pos]} == fcs, {"R7 fcs ", tag},
              {cap[pos+3], cap[pos+2], cap[pos+1], cap[pos]}, fcs);
        c = 32'hFFFFFFFF;
        for (int i = 8; i < pos + 4; i++) c = ref_crc(c, cap[i]);
        check(c == 32'hDEBB20E3, {"R7 residue ", tag}, c, 32'hDEBB20E3);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(!gmii_tx_en && !gmii_tx_er && gmii_txd == 8'h00 && !pl_take,
              "R1 reset in", {gmii_tx_en, gmii_tx_er, pl_take, gmii_txd}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(!gmii_tx_en && !gmii_tx_er && gmii_txd == 8'h00 && !pl_take,
              "R1 idle after reset", {gmii_tx_en, gmii_tx_er, pl_take, gmii_txd}, 0);
    endtask

    task automatic test_single(input int n, input int seed, input string tag);
        int n0;
        fill(n, seed);
        n0 = frames_done;
        @(negedge clk);
        tx_req = 1'b1;
        wait (gmii_tx_en);
        @(negedge clk);
        tx_req = 1'b0;
        wait (frames_done == n0 + 1);
        check_frame(n, tag);
        check(!er_seen, {"R8 tx_er ", tag}, er_seen, 0);
        repeat (14) @(negedge clk);
    endtask

    task automatic test_back_to_back();
        int n0;
        logic [31:0] fcs_a;
        fill(20, 3);
        n0 = frames_done;
        @(negedge clk);
        tx_req = 1'b1;
        wait (frames_done == n0 + 1);
        check_frame(20, "b2b first");
        fcs_a = {cap[71], cap[70], cap[69], cap[68]};
        wait (frames_done == n0 + 2);
        @(negedge clk);
        tx_req = 1'b0;
        check(last_gap == 12, "R9 exact gap", last_gap, 12);
        check_frame(20, "b2b second");
        check({cap[71], cap[70], cap[69], cap[68]} == fcs_a, "R11 same fcs",
              {cap[71], cap[70], cap[69], cap[68]}, fcs_a);
        repeat (14) @(negedge clk);
    endtask

    task automatic test_req_ignored();
        int n0;
        fill(20, 9);
        n0 = frames_done;
        @(negedge clk);
        tx_req = 1'b1;
        wait (gmii_tx_en);
        @(negedge clk);
        tx_req = 1'b0;
        repeat (30) @(negedge clk);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
        wait (frames_done == n0 + 1);
        check_frame(20, "pulse frame");
        repeat (40) @(negedge clk);
        check(frames_done == n0 + 1 && !gmii_tx_en, "R10 mid-frame request ignored",
              frames_done - n0, 1);
    endtask

    initial begin
        test_reset();
        test_single(10, 1, "len10");
        test_single(1, 2, "len1");
        test_single(45, 4, "len45");
        test_single(46, 5, "len46");
        test_single(47, 6, "len47");
        test_single(100, 7, "len100");
        test_back_to_back();
        test_req_ignored();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule